// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls an eight-pin general-purpose I/O port from a small register bus. Software sets three per-pin fields: a direction bit, a data latch bit and an option bit. An input pin never drives its pad. An output pin drives the value in its latch, either push-pull or open-drain. The option bit has two meanings. On an input pin it enables the interrupt. On an output pin it selects the drive type.

Every pin input passes through a synchronizer before any logic uses it. The synchronized level feeds three things: the data read path, the interrupt detector and the alternate-input path to on-chip peripherals. A peripheral can take over any pin with an alternate-enable and drive its own value onto it. The interrupt requests of all enabled pins are merged into one registered port interrupt. One port-wide input sets the sensing to either level-low or any-edge.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the direction, data and option registers all read 0. `pin_oe` is 0 and `irq` is 0.
- R2: A register is written when `bus_sel` and `bus_write` are both high on a rising clock edge. Address 1 is the direction register and address 2 is the option register; both read back what was written. Address 0 is the data register. Address 3 reads as 0.
- R3: A pin whose direction bit is 0 and whose alternate-enable is 0 has `pin_oe` low. Its bit in a read of address 0 is the pin level, sampled through the two-stage synchronizer.
- R4: An output pin (direction bit 1) with option bit 0 is push-pull. It has `pin_oe` high and `pin_out` equal to its data latch bit. Its bit in a read of address 0 is the latch bit.
- R5: An output pin with option bit 1 is open-drain. `pin_out` is 0, and `pin_oe` is high only when the value to drive is 0.
- R6: When `sense_edge` is 0 (level-low sensing), an interrupt-enabled input pin (direction 0, option 1) held low sets `irq` high within five clock cycles. `irq` stays high while the pin stays low, and falls after the pin returns high.
- R7: When `sense_edge` is 1 (any-edge sensing), each rising or falling transition of an interrupt-enabled input pin produces exactly one `irq` pulse of one clock cycle.
- R8: A pin with direction bit 1, or with option bit 0, or with its alternate-enable high never causes `irq`.
- R9: When `alt_out_en` is high for a pin, that pin drives `alt_out_val` even if its direction bit is 0. The drive is push-pull when the option bit is 0 and open-drain when it is 1. The pin's interrupt is off, and the data read still follows the direction bit.
- R10: For a pin with direction 0 and option 0, the `alt_in` bit equals the synchronized pin level. For every other pin the `alt_in` bit is 0.
- R11: No interrupt is raised by synchronizer start-up. If a pin is held steady from reset and its interrupt is enabled during the first cycles, no `irq` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_write | input | 1 | Write qualifier for the access |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 option |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sense_edge | input | 1 | Interrupt sensing: 0 level-low, 1 any-edge |
| pin_in | input | 8 | Pad input levels, asynchronous |
| alt_out_en | input | 8 | Per-pin peripheral takeover of the output |
| alt_out_val | input | 8 | Per-pin peripheral output value |
| alt_in | output | 8 | Synchronized levels passed to peripherals |
| pin_oe | output | 8 | Per-pin pad output enable |
| pin_out | output | 8 | Per-pin pad output value |
| irq | output | 1 | Merged port interrupt request, registered |

## Verification
The bench enables an edge interrupt on a pin that is held high while the synchronizer is still filling after reset. A detector that trusts its reset-valued history would see a false transition and pulse `irq` there. It counts `irq` pulses per transition in edge mode, so a level-style detector would be caught staying high and a missing edge would be caught as zero pulses. It also sets up low pins that are outputs, plain inputs or taken over by a peripheral, which a design that ignored direction or alternate-enable in the interrupt mask would report. Finally, it checks that the data read flips between the pad level and the latch by direction alone, and that open-drain pins never drive a 1.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_OPT  = 2'd2,
        REG_RSVD = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] opt,
    output logic [NUM_PINS-1:0] dat
);
    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] opt;
        logic [NUM_PINS-1:0] dat;
    } regs_t;

    regs_t st_d, st_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        st_d = st_q;
        if (bus_sel && bus_write) begin
            case (sel)
                REG_DATA: st_d.dat = bus_wdata;
                REG_DIR:  st_d.dir = bus_wdata;
                REG_OPT:  st_d.opt = bus_wdata;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Data reads mix per bit: latch for outputs, pad level for inputs.
    always_comb begin
        case (sel)
            REG_DATA: bus_rdata = (st_q.dir & st_q.dat) | (~st_q.dir & pin_sync);
            REG_DIR:  bus_rdata = st_q.dir;
            REG_OPT:  bus_rdata = st_q.opt;
            default:  bus_rdata = '0;
        endcase
    end

    assign dir = st_q.dir;
    assign opt = st_q.opt;
    assign dat = st_q.dat;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] int_en,
    input  logic                sense_edge,
    output logic                irq
);
    // The history is valid once the chain holds a real sample and prev has copied it.
    localparam int ARM_AT = SYNC_STAGES + 1;
    localparam int CNT_W  = $clog2(ARM_AT + 1);

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [CNT_W-1:0]    warm;
        logic                irq;
    } irq_t;

    irq_t st_d, st_q;
    logic                armed;
    logic [NUM_PINS-1:0] hit;

    assign armed = (st_q.warm == CNT_W'(ARM_AT));

    always_comb begin
        st_d = st_q;
        st_d.prev = pin_sync;
        if (!armed) st_d.warm = st_q.warm + 1'b1;
        if (!armed)          hit = '0;
        else if (sense_edge) hit = (pin_sync ^ st_q.prev) & int_en;
        else                 hit = ~pin_sync & int_en;
        st_d.irq = |hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] opt,
    input  logic [NUM_PINS-1:0] dat,
    input  logic [NUM_PINS-1:0] alt_en,
    input  logic [NUM_PINS-1:0] alt_val,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic drive_on;
        logic value;

        assign drive_on = dir[i] | alt_en[i];
        assign value    = alt_en[i] ? alt_val[i] : dat[i];

        always_comb begin
            if (!drive_on) begin
                pin_oe[i]  = 1'b0;
                pin_out[i] = 1'b0;
            end else if (opt[i]) begin
                pin_oe[i]  = ~value;
                pin_out[i] = 1'b0;
            end else begin
                pin_oe[i]  = 1'b1;
                pin_out[i] = value;
            end
        end
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic                sense_edge,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] alt_out_en,
    input  logic [NUM_PINS-1:0] alt_out_val,
    output logic [NUM_PINS-1:0] alt_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                irq
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] dir_w;
    logic [NUM_PINS-1:0] opt_w;
    logic [NUM_PINS-1:0] dat_w;
    logic [NUM_PINS-1:0] int_en;

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .dir       (dir_w),
        .opt       (opt_w),
        .dat       (dat_w)
    );

    // Interrupt needs an input pin, option set, and no peripheral takeover.
    assign int_en = ~dir_w & opt_w & ~alt_out_en;

    gpio_irq #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sync   (pin_sync),
        .int_en     (int_en),
        .sense_edge (sense_edge),
        .irq        (irq)
    );

    gpio_drive #(.NUM_PINS(NUM_PINS)) u_drive (
        .dir     (dir_w),
        .opt     (opt_w),
        .dat     (dat_w),
        .alt_en  (alt_out_en),
        .alt_val (alt_out_val),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    assign alt_in = pin_sync & ~dir_w & ~opt_w;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] dir,
    input logic [NUM_PINS-1:0] opt,
    input logic [NUM_PINS-1:0] alt_en,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] alt_in,
    input logic                irq
);
    assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~(dir | alt_en)) == '0);

    assert_open_drain_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & opt & (dir | alt_en)) == '0);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(~dir & opt & ~alt_en)));

    assert_alt_in_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_in & (dir | opt)) == '0);
endmodule

bind gpio_port_ctrl gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir     (dir_w),
    .opt     (opt_w),
    .alt_en  (alt_out_en),
    .pin_oe  (pin_oe),
    .pin_out (pin_out),
    .alt_in  (alt_in),
    .irq     (irq)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_write = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sense_edge = 1'b0;
    logic [7:0] pin_in = 8'hA5;
    logic [7:0] alt_out_en = 8'h00;
    logic [7:0] alt_out_val = 8'h00;
    logic [7:0] alt_in;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gpio_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sense_edge(sense_edge), .pin_in(pin_in), .alt_out_en(alt_out_en),
        .alt_out_val(alt_out_val), .alt_in(alt_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic setup(input logic [7:0] d, input logic [7:0] o, input logic [7:0] v);
        wr(2'd1, d); wr(2'd2, o); wr(2'd0, v);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_irq(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (irq) c++;
        end
    endtask

    task automatic t_no_false_irq();
        int c;
        // R11: enable edge interrupts while the synchronizer is still filling
        sense_edge = 1'b1;
        @(negedge clk) rst_n = 1'b1;
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 2'd2; bus_wdata = 8'hFF;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
        count_irq(10, c);
        check(c == 0, "R11 start-up irq pulses", c, 0);
        // return to a fresh reset for R1
        @(negedge clk) rst_n = 1'b0;
        sense_edge = 1'b0;
        wait_cyc(2);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd1, d); check(d == 8'h00, "R1 dir after reset", d, 0);
        rd(2'd2, d); check(d == 8'h00, "R1 opt after reset", d, 0);
        check(pin_oe == 8'h00, "R1 pin_oe after reset", pin_oe, 0);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        wr(2'd1, 8'hFF);
        rd(2'd0, d); check(d == 8'h00, "R1 data latch after reset", d, 0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(2'd1, 8'h3C); rd(2'd1, d); check(d == 8'h3C, "R2 dir readback", d, 8'h3C);
        wr(2'd2, 8'hC3); rd(2'd2, d); check(d == 8'hC3, "R2 opt readback", d, 8'hC3);
        rd(2'd3, d); check(d == 8'h00, "R2 reserved read", d, 0);
        setup(8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_input();
        logic [7:0] d;
        setup(8'h00, 8'h00, 8'hFF);
        @(negedge clk) pin_in = 8'h5A;
        wait_cyc(3);
        rd(2'd0, d); check(d == 8'h5A, "R3 input read pad level", d, 8'h5A);
        check(pin_oe == 8'h00, "R3 inputs undriven", pin_oe, 0);
    endtask

    task automatic t_pushpull();
        logic [7:0] d;
        pin_in = 8'h00;
        setup(8'hF0, 8'h00, 8'hA6);
        rd(2'd0, d);
        check(d == 8'hA0, "R4 mixed read latch/pad", d, 8'hA0);
        check(pin_oe == 8'hF0, "R4 push-pull oe", pin_oe, 8'hF0);
        check(pin_out == 8'hA0, "R4 push-pull value", pin_out, 8'hA0);
    endtask

    task automatic t_opendrain();
        setup(8'hFF, 8'hFF, 8'h96);
        wait_cyc(1);
        check(pin_oe == 8'h69, "R5 open-drain oe", pin_oe, 8'h69);
        check(pin_out == 8'h00, "R5 open-drain value", pin_out, 0);
    endtask

    task automatic t_level_irq();
        int c;
        setup(8'h00, 8'h00, 8'h00);
        sense_edge = 1'b0;
        pin_in = 8'hFF;
        wr(2'd2, 8'h02);
        wait_cyc(5);
        check(irq == 1'b0, "R6 no irq while high", irq, 0);
        @(negedge clk) pin_in = 8'hFD;
        wait_cyc(5);
        check(irq == 1'b1, "R6 irq on low level", irq, 1);
        count_irq(6, c);
        check(c == 6, "R6 irq held while low", c, 6);
        @(negedge clk) pin_in = 8'hFF;
        wait_cyc(5);
        check(irq == 1'b0, "R6 irq clears when high", irq, 0);
    endtask

    task automatic t_edge_irq();
        int c;
        sense_edge = 1'b1;
        wr(2'd2, 8'h01);
        wait_cyc(4);
        @(negedge clk) pin_in = 8'hFE;
        count_irq(10, c);
        check(c == 1, "R7 falling edge pulses", c, 1);
        @(negedge clk) pin_in = 8'hFF;
        count_irq(10, c);
        check(c == 1, "R7 rising edge pulses", c, 1);
        sense_edge = 1'b0;
    endtask

    task automatic t_masked_irq();
        int c;
        sense_edge = 1'b0;
        pin_in = 8'h00;
        // pins 0-3 outputs with option 1, pins 4-7 plain inputs
        setup(8'h0F, 8'h0F, 8'hFF);
        count_irq(10, c);
        check(c == 0, "R8 outputs and plain inputs no irq", c, 0);
        pin_in = 8'hFF;
        setup(8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_alt_out();
        int c;
        logic [7:0] d;
        sense_edge = 1'b0;
        pin_in = 8'hFB;
        setup(8'h00, 8'h04, 8'h00);
        @(negedge clk) begin alt_out_en = 8'h04; alt_out_val = 8'h00; end
        count_irq(10, c);
        check(c == 0, "R9 takeover masks irq", c, 0);
        check(pin_oe == 8'h04, "R9 alt open-drain drives 0", pin_oe, 8'h04);
        @(negedge clk) alt_out_val = 8'h04;
        #1 check(pin_oe == 8'h00, "R9 alt open-drain releases 1", pin_oe, 0);
        wr(2'd2, 8'h00);
        #1 check(pin_oe == 8'h04 && pin_out == 8'h04, "R9 alt push-pull", {pin_oe, pin_out}, 16'h0404);
        rd(2'd0, d);
        check(d == 8'hFB, "R9 read stays pad level", d, 8'hFB);
        alt_out_en = 8'h00; alt_out_val = 8'h00;
    endtask

    task automatic t_alt_in();
        pin_in = 8'hFF;
        setup(8'h03, 8'h0C, 8'h00);
        wait_cyc(3);
        check(alt_in == 8'hF0, "R10 alt_in gating", alt_in, 8'hF0);
        @(negedge clk) pin_in = 8'h0F;
        wait_cyc(3);
        check(alt_in == 8'h00, "R10 alt_in follows pad", alt_in, 0);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        t_no_false_irq();
        t_reset();
        t_regs();
        t_input();
        t_pushpull();
        t_opendrain();
        t_level_irq();
        t_edge_irq();
        t_masked_irq();
        t_alt_out();
        t_alt_in();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule